// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides the outcome of a conditional branch once the instruction has been decoded. It takes a 5-bit option field and a 5-bit condition-bit selector, together with the condition register, the count register, the link register, the current PC and a PC-relative target. From these it works out whether the branch is taken and what the next PC is. It also produces the updated count register and the updated link register, each with its own write enable, so that the register file can commit them in the same step.

The option field controls two tests, and each can be switched off on its own. The first is a count test: it decrements the count register and then checks the new value for zero or nonzero. The second is a condition test: it compares one condition-register bit against a polarity bit. The branch is taken only when both tests pass. A 2-bit select chooses the target source. When the target comes from the count register or the link register, its two low bits are cleared so that the target is word aligned.

A request is presented with `req_valid` high. All results appear registered one clock later, with `out_valid` high.

Top module: `br_resolver`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `taken`, `ctr_we` and `lr_we` are 0, and `next_pc`, `ctr_new` and `lr_new` are all zero.
- R2: Results appear one clock after the request. When `req_valid` is low, the next cycle shows `out_valid`, `taken`, `ctr_we` and `lr_we` all at 0, and `next_pc` keeps its previous value.
- R3: When option bit 2 (value 0b00100) is 0 and the target select is not the count register, the count is decremented. In that case `ctr_we`=1 and `ctr_new` = ctr − 1, wrapping modulo 2^32. Otherwise `ctr_we`=0.
- R4: When the count is decremented, the count test passes if the new value is nonzero. If option bit 1 (value 0b00010) is also 1, the test instead passes only if the new value is zero. When the count is not decremented, the count test always passes.
- R5: When option bit 4 (value 0b10000) is 1, the condition test always passes, whatever the condition register holds.
- R6: When option bit 4 is 0, the condition test passes when condition-register bit `cr[31−bi]` equals option bit 3 (value 0b01000). With this mapping, field k occupies bits 31−4k down to 28−4k, in the order LT, GT, EQ, SO.
- R7: `taken` is 1 only when both the count test and the condition test pass. When the branch is not taken, `next_pc` = pc + 4.
- R8: Target select encoding: 0 uses `rel_target` unchanged, 1 uses `ctr` with bits [1:0] cleared, 2 uses `lr` with bits [1:0] cleared, and 3 is treated like 0. When the branch is taken, `next_pc` equals this target.
- R9: When `link_en`=1, `lr_we`=1 and `lr_new` = pc + 4, whether or not the branch is taken. A link-register target uses the link value that was present before this update.
- R10: When the target select is the count register, no decrement takes place (`ctr_we`=0) even if option bit 2 is 0, and the count test passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A branch request is present this cycle |
| bo | input | 5 | Branch option field |
| bi | input | 5 | Condition-bit selector |
| cr | input | 32 | Condition register, 8 fields of LT/GT/EQ/SO |
| ctr | input | 32 | Current count register |
| lr | input | 32 | Current link register |
| pc | input | 32 | Address of the branch |
| rel_target | input | 32 | Precomputed PC-relative target |
| tgt_sel | input | 2 | Target source: 0 relative, 1 count, 2 link, 3 relative |
| link_en | input | 1 | Write pc + 4 to the link register |
| out_valid | output | 1 | Results below belong to the previous request |
| next_pc | output | 32 | Resolved next PC |
| taken | output | 1 | Branch taken |
| ctr_new | output | 32 | Updated count register |
| ctr_we | output | 1 | Commit `ctr_new` |
| lr_new | output | 32 | Updated link register |
| lr_we | output | 1 | Commit `lr_new` |

## Verification
The assertions compare registered outputs with input values one cycle earlier through `$past`. For that to hold, the inputs of a request must be held stable from one clock edge to the next, and reset must put all outputs into a known idle state before the first request. The bench changes inputs only on falling edges, so each request is stable across the rising edge that captures it. It also holds reset for several cycles before the first request, so every `$past` reference points at a cycle that came after reset.

// File: rtl/br_pkg.sv
// Package of shared types and field positions for the branch resolver.
// Assumes a 5-bit option field whose bit positions are fixed by decode.
package br_pkg;
    // Target source select encoding.
    typedef enum logic [1:0] {
        TGT_REL = 2'd0,
        TGT_CTR = 2'd1,
        TGT_LR  = 2'd2,
        TGT_RSV = 2'd3
    } tgt_sel_e;

    // Bit positions inside the option field.
    localparam int OPT_CR_IGNORE = 4;
    localparam int OPT_CR_POL    = 3;
    localparam int OPT_CTR_KEEP  = 2;
    localparam int OPT_CTR_ZERO  = 1;
    localparam int OPT_HINT      = 0;
endpackage

// File: rtl/br_count_unit.sv
// Count test: optionally decrements the count register and judges the
// decremented value for zero or nonzero. Assumes dec_en already folds in
// any target-select override.
module br_count_unit #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctr_in,
    input  logic            dec_en,
    input  logic            want_zero,
    output logic [XLEN-1:0] ctr_dec,
    output logic            cnt_ok
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic dec_is_zero;

    // Decrement with modular wrap.
    always_comb begin
        ctr_dec = ctr_in - ONE;
    end

    // Zero detect on the decremented count and polarity choice.
    always_comb begin
        dec_is_zero = (ctr_dec == '0);
        if (!dec_en)
            cnt_ok = 1'b1;
        else if (want_zero)
            cnt_ok = dec_is_zero;
        else
            cnt_ok = !dec_is_zero;
    end
endmodule

// File: rtl/br_cond_unit.sv
// Condition test: picks one condition-register bit by selector, counting
// from the most significant bit, and compares it against a polarity bit.
// Assumes CR_W equals 2**SEL_W.
module br_cond_unit #(
    parameter int SEL_W = 5,
    parameter int CR_W  = 32
) (
    input  logic [CR_W-1:0]  cr_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             ignore,
    input  logic             polarity,
    output logic             cond_ok
);
    logic [CR_W-1:0] msb_first;
    logic            picked;

    // Reverse the register so index 0 names the leftmost bit.
    for (genvar g = 0; g < CR_W; g++) begin : g_rev
        assign msb_first[g] = cr_in[CR_W-1-g];
    end

    // Bit pick and polarity compare.
    always_comb begin
        picked  = msb_first[sel];
        cond_ok = ignore ? 1'b1 : (picked == polarity);
    end
endmodule

// File: rtl/br_target_unit.sv
// Target mux: chooses relative, count or link target and clears the
// alignment bits on register-indirect sources. Assumes reserved select
// values fall back to the relative target.
module br_target_unit
    import br_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  tgt_sel_e         sel,
    input  logic [XLEN-1:0]  rel_in,
    input  logic [XLEN-1:0]  ctr_in,
    input  logic [XLEN-1:0]  lr_in,
    output logic [XLEN-1:0]  target,
    output logic             from_ctr
);
    logic [XLEN-1:0] align_mask;

    // Mask with the low ALIGN_BITS cleared.
    for (genvar g = 0; g < XLEN; g++) begin : g_mask
        assign align_mask[g] = (g >= ALIGN_BITS);
    end

    // Source selection.
    always_comb begin
        from_ctr = (sel == TGT_CTR);
        unique case (sel)
            TGT_CTR: target = ctr_in & align_mask;
            TGT_LR:  target = lr_in & align_mask;
            default: target = rel_in;
        endcase
    end
endmodule

// File: rtl/br_resolver.sv
// Conditional branch resolver top. Combines count test, condition test and
// target choice, then registers next PC, taken flag and register updates.
// Assumes request inputs are stable across the capturing edge.
module br_resolver
    import br_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OPT_W = 5,
    parameter int SEL_W = 5,
    parameter int INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OPT_W-1:0] bo,
    input  logic [SEL_W-1:0] bi,
    input  logic [XLEN-1:0]  cr,
    input  logic [XLEN-1:0]  ctr,
    input  logic [XLEN-1:0]  lr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rel_target,
    input  logic [1:0]       tgt_sel,
    input  logic             link_en,
    output logic             out_valid,
    output logic [XLEN-1:0]  next_pc,
    output logic             taken,
    output logic [XLEN-1:0]  ctr_new,
    output logic             ctr_we,
    output logic [XLEN-1:0]  lr_new,
    output logic             lr_we
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    tgt_sel_e        sel_e;
    logic [XLEN-1:0] target;
    logic            from_ctr;
    logic            dec_en;
    logic [XLEN-1:0] ctr_dec;
    logic            cnt_ok;
    logic            cond_ok;
    logic [XLEN-1:0] seq_pc;
    logic            take_d;
    logic            unused_hint;

    assign unused_hint = bo[OPT_HINT];

    // Decode select and decide whether the count is decremented.
    always_comb begin
        sel_e  = tgt_sel_e'(tgt_sel);
        dec_en = !bo[OPT_CTR_KEEP] && !from_ctr;
        seq_pc = pc + STEP;
    end

    br_target_unit #(.XLEN(XLEN), .ALIGN_BITS(2)) u_target (
        .sel      (sel_e),
        .rel_in   (rel_target),
        .ctr_in   (ctr),
        .lr_in    (lr),
        .target   (target),
        .from_ctr (from_ctr)
    );

    br_count_unit #(.XLEN(XLEN)) u_count (
        .ctr_in    (ctr),
        .dec_en    (dec_en),
        .want_zero (bo[OPT_CTR_ZERO]),
        .ctr_dec   (ctr_dec),
        .cnt_ok    (cnt_ok)
    );

    br_cond_unit #(.SEL_W(SEL_W), .CR_W(XLEN)) u_cond (
        .cr_in    (cr),
        .sel      (bi),
        .ignore   (bo[OPT_CR_IGNORE]),
        .polarity (bo[OPT_CR_POL]),
        .cond_ok  (cond_ok)
    );

    // Combine both tests.
    always_comb begin
        take_d = cnt_ok && cond_ok;
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            ctr_new   <= '0;
            ctr_we    <= 1'b0;
            lr_new    <= '0;
            lr_we     <= 1'b0;
        end else if (req_valid) begin
            out_valid <= 1'b1;
            next_pc   <= take_d ? target : seq_pc;
            taken     <= take_d;
            ctr_we    <= dec_en;
            if (dec_en)
                ctr_new <= ctr_dec;
            lr_we     <= link_en;
            if (link_en)
                lr_new <= seq_pc;
        end else begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            ctr_we    <= 1'b0;
            lr_we     <= 1'b0;
        end
    end

    // R2: idle cycles carry no result.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !ctr_we && !lr_we));

    // R3: committed count is one below the sampled count.
    a_r3_dec_value: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |-> (ctr_new == $past(ctr) - 1));

    // R10: count-register target never decrements.
    a_r10_no_dec_ctr_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |-> ($past(tgt_sel) != 2'd1));

    // R4: a taken decrement-on-nonzero branch leaves a nonzero count.
    a_r4_nonzero_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ctr_we && !$past(bo[1])) |-> (ctr_new != '0));

    // R7: fall-through goes to the next instruction.
    a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (next_pc == $past(pc) + STEP));

    // R8: register-indirect taken targets are word aligned.
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ($past(tgt_sel) == 2'd1 || $past(tgt_sel) == 2'd2))
            |-> (next_pc[1:0] == 2'b00));

    // R9: link update is the return address of the branch.
    a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (out_valid && lr_new == $past(pc) + STEP));
endmodule

// File: tb/br_resolver_bench.sv
module br_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  bo = '0;
    logic [4:0]  bi = '0;
    logic [31:0] cr = '0;
    logic [31:0] ctr = '0;
    logic [31:0] lr = '0;
    logic [31:0] pc = '0;
    logic [31:0] rel_target = '0;
    logic [1:0]  tgt_sel = '0;
    logic        link_en = 1'b0;
    logic        out_valid;
    logic [31:0] next_pc;
    logic        taken;
    logic [31:0] ctr_new;
    logic        ctr_we;
    logic [31:0] lr_new;
    logic        lr_we;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolver u_br_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bo(bo), .bi(bi),
        .cr(cr), .ctr(ctr), .lr(lr), .pc(pc), .rel_target(rel_target),
        .tgt_sel(tgt_sel), .link_en(link_en), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .ctr_new(ctr_new), .ctr_we(ctr_we),
        .lr_new(lr_new), .lr_we(lr_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge; results are sampled at the next falling edge.
    task automatic issue(input logic [4:0] o, input logic [4:0] s, input logic [31:0] c,
                         input logic [31:0] k, input logic [31:0] l, input logic [31:0] p,
                         input logic [31:0] r, input logic [1:0] t, input logic le);
        req_valid = 1'b1; bo = o; bi = s; cr = c; ctr = k; lr = l; pc = p;
        rel_target = r; tgt_sel = t; link_en = le;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 next_pc", next_pc, 0);
        chk("R1 taken", 32'(taken), 0);
        chk("R1 ctr_new", ctr_new, 0);
        chk("R1 ctr_we", 32'(ctr_we), 0);
        chk("R1 lr_new", lr_new, 0);
        chk("R1 lr_we", 32'(lr_we), 0);
    endtask

    task automatic t_always();
        issue(5'b10100, 0, 0, 32'h9, 0, 32'h1000, 32'h2000, 2'd0, 1'b0);
        chk("R7 always taken", 32'(taken), 1);
        chk("R8 relative target", next_pc, 32'h2000);
        chk("R3 no decrement", 32'(ctr_we), 0);
        chk("R2 out_valid", 32'(out_valid), 1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R2 idle out_valid", 32'(out_valid), 0);
        chk("R2 idle taken", 32'(taken), 0);
        chk("R2 idle ctr_we", 32'(ctr_we), 0);
        chk("R2 idle lr_we", 32'(lr_we), 0);
        chk("R2 idle next_pc held", next_pc, 32'h2000);
    endtask

    task automatic t_count();
        issue(5'b10000, 0, 0, 32'd5, 0, 32'h100, 32'h300, 2'd0, 1'b0);
        chk("R3 dec we", 32'(ctr_we), 1);
        chk("R3 dec value", ctr_new, 32'd4);
        chk("R4 nonzero taken", 32'(taken), 1);
        chk("R4 nonzero target", next_pc, 32'h300);
        issue(5'b10000, 0, 0, 32'd1, 0, 32'h100, 32'h300, 2'd0, 1'b0);
        chk("R4 reached zero not taken", 32'(taken), 0);
        chk("R7 fallthrough", next_pc, 32'h104);
        chk("R3 dec to zero", ctr_new, 32'd0);
        issue(5'b10010, 0, 0, 32'd1, 0, 32'h100, 32'h300, 2'd0, 1'b0);
        chk("R4 want zero taken", 32'(taken), 1);
        issue(5'b10010, 0, 0, 32'd0, 0, 32'h100, 32'h300, 2'd0, 1'b0);
        chk("R4 want zero wrap not taken", 32'(taken), 0);
        chk("R3 wrap value", ctr_new, 32'hFFFF_FFFF);
    endtask

    task automatic t_cond();
        // bi=6 selects field 1 EQ, bit 31-6 = 25
        issue(5'b01100, 5'd6, 32'h0200_0000, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R6 bit set, want 1", 32'(taken), 1);
        issue(5'b01100, 5'd6, 32'hFDFF_FFFF, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R6 bit clear, want 1", 32'(taken), 0);
        chk("R7 cond fallthrough", next_pc, 32'h44);
        issue(5'b00100, 5'd6, 32'hFDFF_FFFF, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R6 bit clear, want 0", 32'(taken), 1);
        issue(5'b01100, 5'd31, 32'h0000_0001, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R6 last field SO", 32'(taken), 1);
        issue(5'b10100, 5'd6, 32'hFDFF_FFFF, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R5 ignore with bit clear", 32'(taken), 1);
        issue(5'b11100, 5'd6, 32'hFDFF_FFFF, 0, 0, 32'h40, 32'h80, 2'd0, 1'b0);
        chk("R5 ignore with polarity set", 32'(taken), 1);
    endtask

    task automatic t_both();
        issue(5'b01000, 5'd0, 32'h8000_0000, 32'd3, 0, 32'h10, 32'h50, 2'd0, 1'b0);
        chk("R7 both pass", 32'(taken), 1);
        issue(5'b01000, 5'd0, 32'h8000_0000, 32'd1, 0, 32'h10, 32'h50, 2'd0, 1'b0);
        chk("R7 count fails", 32'(taken), 0);
        issue(5'b01000, 5'd0, 32'h0, 32'd3, 0, 32'h10, 32'h50, 2'd0, 1'b0);
        chk("R7 cond fails", 32'(taken), 0);
        chk("R3 decrement despite cond fail", ctr_new, 32'd2);
    endtask

    task automatic t_targets();
        issue(5'b10100, 0, 0, 32'h1003, 0, 32'h10, 32'h50, 2'd1, 1'b0);
        chk("R8 count target aligned", next_pc, 32'h1000);
        issue(5'b10000, 0, 0, 32'h2001, 0, 32'h10, 32'h50, 2'd1, 1'b0);
        chk("R10 no decrement on count target", 32'(ctr_we), 0);
        chk("R10 count test passes", 32'(taken), 1);
        chk("R10 target from count", next_pc, 32'h2000);
        issue(5'b10100, 0, 0, 0, 0, 32'h10, 32'h57, 2'd3, 1'b0);
        chk("R8 reserved select relative", next_pc, 32'h57);
    endtask

    task automatic t_link();
        issue(5'b10100, 0, 0, 0, 32'h2007, 32'h100, 32'h50, 2'd2, 1'b1);
        chk("R9 target old link aligned", next_pc, 32'h2004);
        chk("R9 link value", lr_new, 32'h104);
        chk("R9 link we", 32'(lr_we), 1);
        issue(5'b01100, 5'd2, 32'h0, 0, 32'h2007, 32'h200, 32'h50, 2'd2, 1'b1);
        chk("R9 not taken", 32'(taken), 0);
        chk("R9 link we when not taken", 32'(lr_we), 1);
        chk("R9 link value when not taken", lr_new, 32'h204);
        issue(5'b10100, 0, 0, 0, 32'h2007, 32'h300, 32'h50, 2'd0, 1'b0);
        chk("R9 no link", 32'(lr_we), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_always();
        t_idle();
        t_count();
        t_cond();
        t_both();
        t_targets();
        t_link();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule